// File: doc/BRIEF.md
# Single-Port Stalling RAM with Request Serializer

This block is a 4096-word by 16-bit on-chip RAM whose storage array can perform only one access per clock cycle. In one cycle the CPU may present a store request and a load request together. When both of them address the block, the store is carried out first. The block then drops its ready output for one cycle and carries out the load in that cycle. When ready rises again, the loaded word is on the read-data output.

A two-bit mapping input selects which address space the block answers in: program space, data space, both, or neither. When the block answers in neither space, the whole window belongs to off-chip memory. A request is served only if two things hold. The space it names must be enabled, and its address must fall inside a 4096-word window at a parameterized base. Any other request is ignored and never causes a stall.

Top module: `single_port_stall_ram`

## Requirements
- R1: The block stores 4096 words of 16 bits. Offset = addr[11:0] inside the window, so offsets 0x000 and 0xFFF each hold their own word.
- R2: A lone accepted request (only one of the two requests hits) is carried out at the clock edge that accepts it. Ready stays 1. For a read, rd_data shows the word from the cycle after that edge.
- R3: When the store and the load both hit in a cycle where ready is 1, ready is 0 for exactly the next cycle and returns to 1 in the cycle after that. That is one extra cycle for two requests.
- R4: Same-cycle requests are carried out with the store first and the load second. A load of the address being stored returns the new word. rd_data is valid in the cycle where ready returns to 1.
- R5: Requests presented while ready is 0 are ignored. A store presented in the stall cycle writes nothing, and a load address presented in the stall cycle does not replace the held load.
- R6: map_mode encoding: 2'b00 off, 2'b01 program space only, 2'b10 data space only, 2'b11 both. Each request's space bit is 0 for program and 1 for data. A request to a space that is not enabled writes nothing, leaves rd_data unchanged and does not stall.
- R7: A request hits only when addr[15:12] equals BASE[15:12] (BASE defaults to 16'h8000). A request outside the window writes nothing, leaves rd_data unchanged and does not stall.
- R8: rd_data holds its value until the next read that is carried out. Idle cycles and stores do not change it.
- R9: Synchronous reset clears any held load, sets ready to 1 and clears rd_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| map_mode | input | 2 | Space mapping: 00 off, 01 program, 10 data, 11 both |
| wr_req | input | 1 | Store request |
| wr_space | input | 1 | Store space: 0 program, 1 data |
| wr_addr | input | 16 | Store address |
| wr_data | input | 16 | Store data |
| rd_req | input | 1 | Load request |
| rd_space | input | 1 | Load space: 0 program, 1 data |
| rd_addr | input | 16 | Load address |
| ready | output | 1 | 0 while a held load is being carried out |
| rd_data | output | 16 | Word from the most recent load carried out |

## Verification
A lone load changes rd_data one edge after it is accepted. A store and a load together drop ready one edge after acceptance, and the loaded word appears one edge later, when ready comes back. The bench drives each request for exactly one cycle and samples 1 ns after the edge that should produce the result. In the paired case it first checks that ready is 0, then checks the data after one more edge. The ignored-request cases are observed at the ports: ready must stay 1, rd_data must keep its value, and a later load must return the word from before the ignored store.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {
    MAP_OFF  = 2'b00,
    MAP_PROG = 2'b01,
    MAP_DATA = 2'b10,
    MAP_BOTH = 2'b11
  } map_e;

  // space bit: 0 = program, 1 = data; map bit 0 enables program, bit 1 data
  function automatic logic space_enabled(logic [1:0] map, logic space);
    return space ? map[1] : map[0];
  endfunction

  function automatic logic [1:0] req_count(logic a, logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/spr_decode.sv
module spr_decode #(
  parameter int AW = 16,
  parameter int OW = 12,
  parameter logic [AW-1:0] BASE = 16'h8000
) (
  input  logic          req,
  input  logic          space,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    map,
  output logic          hit,
  output logic [OW-1:0] off
);
  localparam int HW = AW - OW;
  localparam logic [HW-1:0] BASE_HI = BASE[AW-1:OW];

  logic in_window;
  assign in_window = (addr[AW-1:OW] == BASE_HI);
  assign hit = req && in_window && spr_pkg::space_enabled(map, space);
  assign off = addr[OW-1:0];
endmodule

// File: rtl/spr_serial.sv
module spr_serial #(
  parameter int OW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_hit,
  input  logic [OW-1:0] rd_off,
  output logic          ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [OW-1:0] mem_off,
  output logic [DW-1:0] mem_wdata
);
  logic          pend;
  logic [OW-1:0] pend_off;
  logic          accept;
  logic [1:0]    n_hits;
  logic          stall_start;

  assign accept      = !pend;
  assign n_hits      = spr_pkg::req_count(wr_hit && accept, rd_hit && accept);
  assign stall_start = (n_hits == 2'd2);
  assign ready       = !pend;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_off   = wr_off;
    mem_wdata = wr_data;
    if (pend) begin
      mem_en  = 1'b1;
      mem_off = pend_off;
    end else if (wr_hit) begin
      mem_en  = 1'b1;
      mem_we  = 1'b1;
    end else if (rd_hit) begin
      mem_en  = 1'b1;
      mem_off = rd_off;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_off <= '0;
    end else if (pend) begin
      pend     <= 1'b0;
    end else if (stall_start) begin
      pend     <= 1'b1;
      pend_off <= rd_off;
    end
  end

  assert_pair_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    stall_start |=> !ready);
  assert_stall_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ready);
  assert_single_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && (wr_hit != rd_hit)) |=> ready);
  assert_write_first_R4: assert property (@(posedge clk) disable iff (rst)
    stall_start |-> (mem_en && mem_we));
  assert_no_write_in_stall_R5: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !mem_we);
  assert_reset_ready_R9: assert property (@(posedge clk)
    rst |=> ready);
endmodule

// File: rtl/spr_array.sv
module spr_array #(
  parameter int OW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << OW;

  logic [DW-1:0] mem [DEPTH];
  logic          do_read;

  assign do_read = en && !we;

  always_ff @(posedge clk) begin
    if (en && we) mem[off] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (do_read) rdata <= mem[off];
  end

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !do_read |=> $stable(rdata));
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (rdata == '0));
endmodule

// File: rtl/single_port_stall_ram.sv
module single_port_stall_ram #(
  parameter int AW = 16,
  parameter int OW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] BASE = 16'h8000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    map_mode,
  input  logic          wr_req,
  input  logic          wr_space,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          rd_space,
  input  logic [AW-1:0] rd_addr,
  output logic          ready,
  output logic [DW-1:0] rd_data
);
  logic          wr_hit, rd_hit;
  logic [OW-1:0] wr_off, rd_off;
  logic          mem_en, mem_we;
  logic [OW-1:0] mem_off;
  logic [DW-1:0] mem_wdata;

  spr_decode #(.AW(AW), .OW(OW), .BASE(BASE)) u_wr_dec (
    .req(wr_req), .space(wr_space), .addr(wr_addr), .map(map_mode),
    .hit(wr_hit), .off(wr_off));

  spr_decode #(.AW(AW), .OW(OW), .BASE(BASE)) u_rd_dec (
    .req(rd_req), .space(rd_space), .addr(rd_addr), .map(map_mode),
    .hit(rd_hit), .off(rd_off));

  spr_serial #(.OW(OW), .DW(DW)) u_serial (
    .clk(clk), .rst(rst),
    .wr_hit(wr_hit), .wr_off(wr_off), .wr_data(wr_data),
    .rd_hit(rd_hit), .rd_off(rd_off),
    .ready(ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_off(mem_off), .mem_wdata(mem_wdata));

  spr_array #(.OW(OW), .DW(DW)) u_array (
    .clk(clk), .rst(rst), .en(mem_en), .we(mem_we), .off(mem_off),
    .wdata(mem_wdata), .rdata(rd_data));

  assert_unmapped_no_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (ready && map_mode == spr_pkg::MAP_OFF) |=> ready);
  assert_off_window_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (ready && wr_addr[AW-1:OW] != BASE[AW-1:OW]) |=> ready);
endmodule

// File: tb/test_single_port_stall_ram.sv
`timescale 1ns/1ps
module test_single_port_stall_ram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  map_mode = 2'b11;
  logic        wr_req = 1'b0, wr_space = 1'b1, rd_req = 1'b0, rd_space = 1'b1;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic        ready;
  logic [15:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  single_port_stall_ram i_single_port_stall_ram (
    .clk(clk), .rst(rst), .map_mode(map_mode),
    .wr_req(wr_req), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_space(rd_space), .rd_addr(rd_addr),
    .ready(ready), .rd_data(rd_data));

  // {we, re, waddr, wdata, raddr, stall, chk, expected}, data space, map both
  localparam int NV = 9;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h8000, 16'h1111, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b0, 16'h8FFF, 16'h2222, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h8000, 1'b0, 1'b1, 16'h1111},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h8FFF, 1'b0, 1'b1, 16'h2222},
    {1'b1, 1'b1, 16'h8010, 16'h3333, 16'h8000, 1'b1, 1'b1, 16'h1111},
    {1'b1, 1'b1, 16'h8010, 16'h4444, 16'h8010, 1'b1, 1'b1, 16'h4444},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h8010, 1'b0, 1'b1, 16'h4444},
    {1'b1, 1'b1, 16'h9000, 16'h5555, 16'h8000, 1'b0, 1'b1, 16'h1111},
    {1'b1, 1'b1, 16'h7FFF, 16'h6666, 16'h8FFF, 1'b0, 1'b1, 16'h2222}
  };

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of requests, return 1 ns after the accepting edge
  task automatic op(input logic we, input logic wsp, input logic [15:0] wa,
                    input logic [15:0] wd, input logic re, input logic rsp,
                    input logic [15:0] ra);
    wr_req = we; wr_space = wsp; wr_addr = wa; wr_data = wd;
    rd_req = re; rd_space = rsp; rd_addr = ra;
    @(posedge clk); #1;
    wr_req = 1'b0; rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    rst = 1'b0;
    chk(ready == 1'b1, "R9 ready after reset", {15'b0, ready}, 16'h1);
    chk(rd_data == 16'h0, "R9 rd_data after reset", rd_data, 16'h0);

    // table: R1 R2 R3 R4 R7
    for (int v = 0; v < NV; v++) begin
      logic [67:0] e;
      e = VEC[v];
      op(e[67], 1'b1, e[65:50], e[49:34], e[66], 1'b1, e[33:18]);
      chk(ready == !e[17], $sformatf("R3/R2 vec%0d ready", v), {15'b0, ready},
          {15'b0, !e[17]});
      if (e[17]) begin
        idle(1);
        chk(ready == 1'b1, $sformatf("R3 vec%0d ready back", v), {15'b0, ready}, 16'h1);
      end
      if (e[16])
        chk(rd_data == e[15:0], $sformatf("R1/R4/R7 vec%0d rd_data", v), rd_data, e[15:0]);
    end

    // R8: rd_data holds through idles and stores
    idle(3);
    chk(rd_data == 16'h2222, "R8 hold over idle", rd_data, 16'h2222);
    op(1'b1, 1'b1, 16'h8000, 16'h1111, 1'b0, 1'b1, 16'h0);
    chk(rd_data == 16'h2222, "R8 hold over store", rd_data, 16'h2222);

    // R5: requests during the stall cycle are ignored
    op(1'b1, 1'b1, 16'h8020, 16'h0000, 1'b0, 1'b1, 16'h0);
    op(1'b1, 1'b1, 16'h8030, 16'h0001, 1'b1, 1'b1, 16'h8000);
    chk(ready == 1'b0, "R3 stall entered", {15'b0, ready}, 16'h0);
    op(1'b1, 1'b1, 16'h8020, 16'h7777, 1'b1, 1'b1, 16'h8FFF);
    chk(ready == 1'b1, "R3 stall left", {15'b0, ready}, 16'h1);
    chk(rd_data == 16'h1111, "R5 held load address kept", rd_data, 16'h1111);
    op(1'b0, 1'b1, 16'h0, 16'h0, 1'b1, 1'b1, 16'h8020);
    chk(rd_data == 16'h0000, "R5 stall store dropped", rd_data, 16'h0000);
    op(1'b0, 1'b1, 16'h0, 16'h0, 1'b1, 1'b1, 16'h8030);
    chk(rd_data == 16'h0001, "R4 paired store landed", rd_data, 16'h0001);

    // R6: mapping modes
    map_mode = 2'b01;
    op(1'b1, 1'b1, 16'h8000, 16'hAAAA, 1'b0, 1'b1, 16'h0);
    chk(ready == 1'b1, "R6 prog-only data store no stall", {15'b0, ready}, 16'h1);
    op(1'b1, 1'b1, 16'h8000, 16'hBBBB, 1'b1, 1'b0, 16'h8FFF);
    chk(ready == 1'b1, "R6 prog-only single hit no stall", {15'b0, ready}, 16'h1);
    chk(rd_data == 16'h2222, "R6 program-space load", rd_data, 16'h2222);
    map_mode = 2'b10;
    op(1'b0, 1'b1, 16'h0, 16'h0, 1'b1, 1'b0, 16'h8000);
    chk(rd_data == 16'h2222, "R6 data-only program load ignored", rd_data, 16'h2222);
    op(1'b0, 1'b1, 16'h0, 16'h0, 1'b1, 1'b1, 16'h8000);
    chk(rd_data == 16'h1111, "R6 data-space store was dropped", rd_data, 16'h1111);
    map_mode = 2'b00;
    op(1'b1, 1'b1, 16'h8000, 16'hCCCC, 1'b1, 1'b1, 16'h8FFF);
    chk(ready == 1'b1, "R6 off no stall", {15'b0, ready}, 16'h1);
    chk(rd_data == 16'h1111, "R6 off load ignored", rd_data, 16'h1111);
    map_mode = 2'b11;
    op(1'b0, 1'b1, 16'h0, 16'h0, 1'b1, 1'b0, 16'h8000);
    chk(rd_data == 16'h1111, "R6 off store dropped", rd_data, 16'h1111);

    // R9: reset during a stall clears the held load
    op(1'b1, 1'b1, 16'h8040, 16'h9999, 1'b1, 1'b1, 16'h8FFF);
    chk(ready == 1'b0, "R3 stall before reset", {15'b0, ready}, 16'h0);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    chk(ready == 1'b1, "R9 ready after mid-stall reset", {15'b0, ready}, 16'h1);
    chk(rd_data == 16'h0, "R9 rd_data cleared", rd_data, 16'h0);
    idle(1);
    chk(rd_data == 16'h0 && ready, "R9 held load discarded", rd_data, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule